// File: doc/BRIEF.md
# Fractional-Period Time-of-Day Counter

This block keeps a running time of day in seconds, nanoseconds and a 32-bit fraction of a nanosecond. Every clock cycle of the local reference it adds a programmable period, expressed as 32.32 fixed-point nanoseconds, to the nanosecond-plus-fraction accumulator. When the nanosecond field reaches one second it rolls over, keeps the excess and carries into a 32-bit seconds count. For a reference of F Hz the nominal period word is (10^9 << 32) / F. Because the period has a fraction, clocks that do not divide a nanosecond evenly still keep exact long-term time.

Software or a control block drives a simple write port. Through it, it loads the period word, stages a target time or an adjustment delta, and writes a control word. The control word enables counting and can request one atomic operation: set, increment or decrement. The operation is applied on a single clock edge, so readers of the live time never see a partially updated value. The time outputs feed capture and pulse-generation logic directly.

Top module: `ptod_counter`

## Requirements
- R1: After a synchronous active-low reset the seconds, nanoseconds and fraction outputs are zero, counting is off, no operation is pending and the period word is zero.
- R2: While counting is on and no operation is pending, each clock edge adds the period word (whole nanoseconds in bits 63:32, fraction in bits 31:0, write address 1) to the {nanoseconds, fraction} pair, and a carry out of the fraction enters the nanoseconds.
- R3: The nanosecond field rolls over exactly when it reaches 1,000,000,000. It then keeps the excess over 10^9 and the seconds count increments, modulo 2^32. A value of 999,999,999 and any fraction never rolls over.
- R4: Bit 0 of the control word (write address 0) enables counting and is reflected on `count_on`. While it is 0 and no operation is pending, the time outputs hold.
- R5: Bits 28:26 of the control word request an operation: code 1 sets, code 3 increments, code 4 decrements. The operation is applied on the clock edge after the control write. `op_pend` shows the code for exactly that one cycle and is 0 again afterwards.
- R6: Set loads nanoseconds and fraction from the staged time word (write address 2: nanoseconds in bits 63:32, fraction in bits 31:0) and seconds from the staged seconds word (write address 3, bits 31:0).
- R7: Increment adds the staged time word to the current {nanoseconds, fraction}. If the result reaches 10^9 ns, the excess is kept and one second is carried.
- R8: Decrement subtracts the staged time word. If the result is below zero, 10^9 ns is added back and one second is borrowed from the seconds count.
- R9: No period is added on the edge where an operation is applied, even while counting is on.
- R10: A period write is used from the next clock edge on. The edge that captures it still adds the previous period, and the write itself does not alter the time.
- R11: Control-word operation codes other than 1, 3 and 4 are ignored: `op_pend` stays 0 and the time proceeds exactly as it would without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 3 | Register address: 0 control, 1 period, 2 staged time, 3 staged seconds |
| wr_data | input | 64 | Write data |
| tod_sec | output | 32 | Live seconds count |
| tod_ns | output | 32 | Live nanoseconds, 0 to 999,999,999 |
| tod_frac | output | 32 | Live fraction of a nanosecond, in units of 2^-32 ns |
| count_on | output | 1 | Counting enable currently in force |
| op_pend | output | 3 | Operation code being applied this cycle, 0 when idle |

## Verification
The state lives directly on the outputs, so a wrong accumulator value is visible on the very next sample after the faulty edge. If the rollover compare is off by one, or the wrap clears the excess instead of keeping it, the bench sees the error at the first crossing of a second, as a nanosecond value of zero instead of the carried remainder. A wrong seconds step shows in the same cycle. A fault in the operation path, such as an extra period added, a missing borrow or a pending code that is not cleared, shows one or two cycles after the control write: at the edge the operation is applied, or at the edge after it.

// File: rtl/ptod_pkg.sv
// Shared definitions for the time-of-day counter: operation codes,
// register addresses and control-word field positions.
package ptod_pkg;

    // Atomic operation codes carried in the control word.
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_SET  = 3'd1,
        OP_INC  = 3'd3,
        OP_DEC  = 3'd4
    } tod_op_e;

    // Register addresses on the write port.
    localparam int unsigned REG_CTRL    = 0;
    localparam int unsigned REG_PERIOD  = 1;
    localparam int unsigned REG_STG_T   = 2;
    localparam int unsigned REG_STG_SEC = 3;

    // Control-word field positions.
    localparam int unsigned CTRL_EN_BIT = 0;
    localparam int unsigned CTRL_OP_LSB = 26;
    localparam int unsigned CTRL_OP_MSB = 28;

    // True for the codes the block acts upon.
    function automatic logic op_is_legal(input logic [2:0] code);
        return (code == OP_SET) || (code == OP_INC) || (code == OP_DEC);
    endfunction

endpackage

// File: rtl/ptod_regs.sv
// Register bank of the time-of-day counter.
// Holds the enable, the one-cycle operation request, the period word and
// the staged operands. Assumes wr_data is at least CTRL_OP_MSB+1 bits wide.
module ptod_regs
    import ptod_pkg::*;
#(
    parameter int unsigned SEC_W  = 32,
    parameter int unsigned NS_W   = 32,
    parameter int unsigned FRAC_W = 32,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [NS_W+FRAC_W-1:0]   wr_data,
    output logic                     en_q,
    output tod_op_e                  op_q,
    output logic [NS_W+FRAC_W-1:0]   period_q,
    output logic [NS_W+FRAC_W-1:0]   stg_time_q,
    output logic [SEC_W-1:0]         stg_sec_q
);

    logic [2:0] wr_code;

    // Extract the requested operation code from the write data.
    always_comb wr_code = wr_data[CTRL_OP_MSB:CTRL_OP_LSB];

    // Capture writes; the operation request lasts for one cycle only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            op_q       <= OP_NONE;
            period_q   <= '0;
            stg_time_q <= '0;
            stg_sec_q  <= '0;
        end else begin
            op_q <= OP_NONE;
            if (wr_en) begin
                if (wr_addr == ADDR_W'(REG_CTRL)) begin
                    en_q <= wr_data[CTRL_EN_BIT];
                    if (op_is_legal(wr_code)) begin
                        op_q <= tod_op_e'(wr_code);
                    end
                end else if (wr_addr == ADDR_W'(REG_PERIOD)) begin
                    period_q <= wr_data;
                end else if (wr_addr == ADDR_W'(REG_STG_T)) begin
                    stg_time_q <= wr_data;
                end else if (wr_addr == ADDR_W'(REG_STG_SEC)) begin
                    stg_sec_q <= wr_data[SEC_W-1:0];
                end
            end
        end
    end

endmodule

// File: rtl/ptod_next.sv
// Next-state arithmetic of the time-of-day counter.
// Purely combinational: advances by the period, or applies set, increment
// or decrement, with rollover at NS_PER_SEC that keeps the excess.
// Assumes the current nanoseconds, period and deltas are each below one second.
module ptod_next
    import ptod_pkg::*;
#(
    parameter int unsigned SEC_W      = 32,
    parameter int unsigned NS_W       = 32,
    parameter int unsigned FRAC_W     = 32,
    parameter int unsigned NS_PER_SEC = 1_000_000_000
) (
    input  logic                   en,
    input  tod_op_e                op,
    input  logic [NS_W+FRAC_W-1:0] period,
    input  logic [NS_W+FRAC_W-1:0] stg_time,
    input  logic [SEC_W-1:0]       stg_sec,
    input  logic [SEC_W-1:0]       cur_sec,
    input  logic [NS_W+FRAC_W-1:0] cur_time,
    output logic [SEC_W-1:0]       nxt_sec,
    output logic [NS_W+FRAC_W-1:0] nxt_time
);

    localparam int unsigned TIME_W = NS_W + FRAC_W;
    localparam logic [NS_W-1:0] NS_LIM = NS_W'(NS_PER_SEC);
    localparam logic [TIME_W:0] ROLL  = {1'b0, NS_LIM, {FRAC_W{1'b0}}};

    logic [TIME_W:0] cur_x;
    logic [TIME_W:0] addend;
    logic [TIME_W:0] sum;
    logic [TIME_W:0] diff;
    logic [TIME_W:0] wrapped;

    // Form the sum for advance/increment and the difference for decrement.
    always_comb begin
        cur_x  = {1'b0, cur_time};
        addend = (op == OP_INC) ? {1'b0, stg_time} : {1'b0, period};
        sum    = cur_x + addend;
        diff   = cur_x - {1'b0, stg_time};
        wrapped = diff + ROLL;
    end

    // Select the next time according to the pending operation.
    always_comb begin
        nxt_sec  = cur_sec;
        nxt_time = cur_time;
        case (op)
            OP_SET: begin
                nxt_sec  = stg_sec;
                nxt_time = stg_time;
            end
            OP_DEC: begin
                if (diff[TIME_W]) begin
                    nxt_time = wrapped[TIME_W-1:0];
                    nxt_sec  = cur_sec - 1'b1;
                end else begin
                    nxt_time = diff[TIME_W-1:0];
                end
            end
            default: begin
                if ((op == OP_INC) || en) begin
                    if (sum >= ROLL) begin
                        nxt_time = TIME_W'(sum - ROLL);
                        nxt_sec  = cur_sec + 1'b1;
                    end else begin
                        nxt_time = sum[TIME_W-1:0];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/ptod_counter.sv
// Time-of-day counter top level.
// Instantiates the register bank and the next-state arithmetic and holds
// the live seconds and {nanoseconds, fraction} state.
// Assumes the programmed period is below one second.
module ptod_counter
    import ptod_pkg::*;
#(
    parameter int unsigned SEC_W      = 32,
    parameter int unsigned NS_W       = 32,
    parameter int unsigned FRAC_W     = 32,
    parameter int unsigned ADDR_W     = 3,
    parameter int unsigned NS_PER_SEC = 1_000_000_000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [NS_W+FRAC_W-1:0] wr_data,
    output logic [SEC_W-1:0]       tod_sec,
    output logic [NS_W-1:0]        tod_ns,
    output logic [FRAC_W-1:0]      tod_frac,
    output logic                   count_on,
    output logic [2:0]             op_pend
);

    localparam int unsigned TIME_W = NS_W + FRAC_W;

    logic              en_q;
    tod_op_e           op_q;
    logic [TIME_W-1:0] period_q;
    logic [TIME_W-1:0] stg_time_q;
    logic [SEC_W-1:0]  stg_sec_q;
    logic [SEC_W-1:0]  sec_q;
    logic [TIME_W-1:0] time_q;
    logic [SEC_W-1:0]  sec_d;
    logic [TIME_W-1:0] time_d;

    ptod_regs #(
        .SEC_W (SEC_W),
        .NS_W  (NS_W),
        .FRAC_W(FRAC_W),
        .ADDR_W(ADDR_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .en_q      (en_q),
        .op_q      (op_q),
        .period_q  (period_q),
        .stg_time_q(stg_time_q),
        .stg_sec_q (stg_sec_q)
    );

    ptod_next #(
        .SEC_W     (SEC_W),
        .NS_W      (NS_W),
        .FRAC_W    (FRAC_W),
        .NS_PER_SEC(NS_PER_SEC)
    ) i_next (
        .en      (en_q),
        .op      (op_q),
        .period  (period_q),
        .stg_time(stg_time_q),
        .stg_sec (stg_sec_q),
        .cur_sec (sec_q),
        .cur_time(time_q),
        .nxt_sec (sec_d),
        .nxt_time(time_d)
    );

    // Hold the live time; every edge takes the computed next value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= '0;
            time_q <= '0;
        end else begin
            sec_q  <= sec_d;
            time_q <= time_d;
        end
    end

    // Drive the outputs from the held state.
    always_comb begin
        tod_sec  = sec_q;
        tod_ns   = time_q[TIME_W-1:FRAC_W];
        tod_frac = time_q[FRAC_W-1:0];
        count_on = en_q;
        op_pend  = op_q;
    end

endmodule

// File: rtl/ptod_checks.sv
// Port-level properties of the time-of-day counter, bound to the top.
// Assumes the programmed period is below one second.
module ptod_checks #(
    parameter int unsigned SEC_W  = 32,
    parameter int unsigned NS_W   = 32,
    parameter int unsigned FRAC_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              count_on,
    input logic [2:0]        op_pend,
    input logic [SEC_W-1:0]  tod_sec,
    input logic [NS_W-1:0]   tod_ns,
    input logic [FRAC_W-1:0] tod_frac
);

    // R5
    op_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_pend != 3'd0) |=> (op_pend == 3'd0));

    // R11
    op_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_pend == 3'd0) || (op_pend == 3'd1) || (op_pend == 3'd3) || (op_pend == 3'd4));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_on && (op_pend == 3'd0)) |=>
            ($stable(tod_sec) && $stable(tod_ns) && $stable(tod_frac)));

    // R3
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_pend == 3'd0) |=>
            ((tod_sec == $past(tod_sec)) || (tod_sec == $past(tod_sec) + 1'b1)));

endmodule

bind ptod_counter ptod_checks #(
    .SEC_W (SEC_W),
    .NS_W  (NS_W),
    .FRAC_W(FRAC_W)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .count_on(count_on),
    .op_pend (op_pend),
    .tod_sec (tod_sec),
    .tod_ns  (tod_ns),
    .tod_frac(tod_frac)
);

// File: tb/test_ptod_counter.sv
module test_ptod_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [31:0] tod_sec, tod_ns, tod_frac;
    logic        count_on;
    logic [2:0]  op_pend;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    ptod_counter i_ptod_counter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tod_sec(tod_sec), .tod_ns(tod_ns),
        .tod_frac(tod_frac), .count_on(count_on), .op_pend(op_pend)
    );

    typedef struct packed {
        logic [31:0] sec0;
        logic [31:0] ns0;
        logic [31:0] frac0;
        logic [63:0] per;
        logic [15:0] k;
        logic [31:0] esec;
        logic [31:0] ens;
        logic [31:0] efrac;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{32'd5, 32'd100, 32'h0, 64'h8_0000_0000, 16'd10, 32'd5, 32'd180, 32'h0},
        '{32'd0, 32'd0, 32'h0, 64'h3_5555_5555, 16'd6, 32'd0, 32'd19, 32'hFFFF_FFFE},
        '{32'd7, 32'd999_999_990, 32'h0, 64'h8_0000_0000, 16'd3, 32'd8, 32'd14, 32'h0},
        '{32'd2, 32'd999_999_992, 32'h0, 64'h8_0000_0000, 16'd1, 32'd3, 32'd0, 32'h0},
        '{32'd2, 32'd999_999_991, 32'h0, 64'h8_0000_0000, 16'd1, 32'd2, 32'd999_999_999, 32'h0},
        '{32'hFFFF_FFFF, 32'd999_999_999, 32'hC000_0000, 64'h0_8000_0000, 16'd1, 32'd0, 32'd0, 32'h4000_0000},
        '{32'd1, 32'd50, 32'h1234, 64'h0, 16'd5, 32'd1, 32'd50, 32'h1234},
        '{32'd0, 32'd999_999_000, 32'h0, 64'h4_0000_0000, 16'd300, 32'd1, 32'd200, 32'h0}
    };

    task automatic chk_val(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_time(input string req, input logic [31:0] s, input logic [31:0] n,
                            input logic [31:0] f);
        checks++;
        if (tod_sec !== s || tod_ns !== n || tod_frac !== f) begin
            errors++;
            $display("FAIL %s: actual=%0d.%0d+%h expected=%0d.%0d+%h",
                     req, tod_sec, tod_ns, tod_frac, s, n, f);
        end
    endtask

    // Write one register; starts and ends at a falling edge.
    task automatic wr(input int a, input logic [63:0] d);
        wr_en   = 1'b1;
        wr_addr = 3'(a);
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic [63:0] ctrl(input logic [2:0] code, input logic en);
        return (64'(code) << 26) | 64'(en);
    endfunction

    // Load a time with counting off; returns with the time applied.
    task automatic do_set(input logic [31:0] s, input logic [31:0] n, input logic [31:0] f);
        wr(2, {n, f});
        wr(3, 64'(s));
        wr(0, ctrl(3'd1, 1'b0));
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_time("R1 time", 32'd0, 32'd0, 32'd0);
        chk_val("R1 count_on", 64'(count_on), 64'd0);
        chk_val("R1 op_pend", 64'(op_pend), 64'd0);
        // R1 period zero: enabling without a period write leaves time at zero
        wr(0, ctrl(3'd0, 1'b1));
        chk_val("R4 count_on", 64'(count_on), 64'd1);
        repeat (3) @(negedge clk);
        chk_time("R1 period", 32'd0, 32'd0, 32'd0);
        wr(0, ctrl(3'd0, 1'b0));

        // Table walk: R2 R3 R6
        for (int i = 0; i < NVEC; i++) begin
            wr(1, VEC[i].per);
            do_set(VEC[i].sec0, VEC[i].ns0, VEC[i].frac0);
            chk_time("R6 set", VEC[i].sec0, VEC[i].ns0, VEC[i].frac0);
            wr(0, ctrl(3'd0, 1'b1));
            repeat (int'(VEC[i].k)) @(negedge clk);
            chk_time("R2 R3 advance", VEC[i].esec, VEC[i].ens, VEC[i].efrac);
            wr(0, ctrl(3'd0, 1'b0));
        end

        // R5 pending code visible for one cycle, then cleared
        wr(2, {32'd999_999_000, 32'h8000_0000});
        wr(3, 64'd3);
        wr(0, ctrl(3'd1, 1'b0));
        chk_val("R5 op_pend set", 64'(op_pend), 64'd1);
        @(negedge clk);
        chk_val("R5 op_pend clear", 64'(op_pend), 64'd0);
        chk_time("R6 loaded", 32'd3, 32'd999_999_000, 32'h8000_0000);

        // R7 increment with carry into seconds
        wr(2, {32'd2000, 32'h8000_0000});
        wr(0, ctrl(3'd3, 1'b0));
        @(negedge clk);
        chk_time("R7 inc", 32'd4, 32'd1001, 32'h0);

        // R8 decrement with borrow, then without
        do_set(32'd10, 32'd500, 32'h0);
        wr(2, {32'd1000, 32'h4000_0000});
        wr(0, ctrl(3'd4, 1'b0));
        @(negedge clk);
        chk_time("R8 dec borrow", 32'd9, 32'd999_999_499, 32'hC000_0000);
        wr(2, {32'd0, 32'hC000_0000});
        wr(0, ctrl(3'd4, 1'b0));
        @(negedge clk);
        chk_time("R8 dec", 32'd9, 32'd999_999_499, 32'h0);

        // R4 hold while disabled
        repeat (4) @(negedge clk);
        chk_time("R4 hold", 32'd9, 32'd999_999_499, 32'h0);

        // R9 no period added on the operation edge
        wr(1, 64'h8_0000_0000);
        do_set(32'd0, 32'd0, 32'h0);
        wr(2, {32'd100, 32'h0});
        wr(0, ctrl(3'd3, 1'b1));
        chk_time("R9 before", 32'd0, 32'd0, 32'h0);
        @(negedge clk);
        chk_time("R9 op edge", 32'd0, 32'd100, 32'h0);
        @(negedge clk);
        chk_time("R2 resume", 32'd0, 32'd108, 32'h0);

        // R10 new period from the next edge on
        wr(1, 64'h2_0000_0000);
        chk_time("R10 old period", 32'd0, 32'd116, 32'h0);
        @(negedge clk);
        chk_time("R10 new period", 32'd0, 32'd118, 32'h0);

        // R11 undefined codes ignored
        wr(0, ctrl(3'd2, 1'b1));
        chk_val("R11 code2 pend", 64'(op_pend), 64'd0);
        chk_time("R11 code2 time", 32'd0, 32'd120, 32'h0);
        @(negedge clk);
        chk_time("R11 code2 next", 32'd0, 32'd122, 32'h0);
        wr(0, ctrl(3'd7, 1'b1));
        chk_val("R11 code7 pend", 64'(op_pend), 64'd0);
        @(negedge clk);
        chk_time("R11 code7 next", 32'd0, 32'd126, 32'h0);
        wr(0, ctrl(3'd0, 1'b0));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule